// File: doc/BRIEF.md
# Tearing-Effect Start Synchronizer

This block holds back the start of a display transmit transaction until the panel's tearing-effect (TE) signal says the frame is safe to overwrite. A transaction is requested with a one-cycle `start_i` pulse and a 2-bit sync selection. Without sync, the transmit engine is released at once. With sync, the block waits for the chosen TE edge and then waits a further programmable delay before it releases.

The TE pin is asynchronous, so it passes through a two-flop synchronizer before edge detection. The release delay is counted in slow ticks. A first power-of-two prescaler divides the module clock by 2^ratio0. A second stage divides that by 2^ratio1. If no qualifying edge arrives within a programmable number of slow ticks, the block releases anyway and raises a timeout pulse beside the release.

Top module: `te_start_sync`

## Requirements
- R1: When `start_i` is sampled high while idle with `mode_i` equal to 0 (no sync) or 3 (treated as no sync), `release_o` is high for the next cycle.
- R2: With `mode_i` = 1, the block waits for a rising edge of the synchronized TE. If TE rises before clock edge k, the edge is detected at clock edge k+2. With a delay of 0, `release_o` is high in the cycle after that detection edge.
- R3: With `mode_i` = 2, the same rule applies to a falling TE edge. An edge of the other polarity has no effect on the release.
- R4: With a nonzero `delay_i` = D, release follows D slow-tick periods after the detection edge, that is, in the cycle after clock edge E + D·T, where E is the detection edge.
- R5: The slow-tick period T is 2^`ratio1_i` periods of a first-stage tick, whose own period is 2^`ratio0_i` module-clock cycles. So T = 2^(ratio0+ratio1) cycles, counted from the start or from the detected edge.
- R6: With `timeout_i` = N ≠ 0, if no qualifying edge is detected by clock edge S + N·T (S being the start edge), `release_o` and `timeout_o` are high together in the next cycle. A qualifying edge detected on that same clock edge wins, and no timeout is raised.
- R7: With `timeout_i` = 0, the wait never times out and `timeout_o` stays low.
- R8: A `start_i` received while a transaction is waiting or delaying is ignored. TE edges while idle are ignored.
- R9: After reset, `release_o` and `timeout_o` are low. `timeout_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| te_i | input | 1 | Tearing-effect pin from the panel, asynchronous |
| start_i | input | 1 | One-cycle transaction start request |
| mode_i | input | 2 | Sync selection: 0 none, 1 rising, 2 falling, 3 none |
| ratio0_i | input | RATIO_W | First prescaler exponent |
| ratio1_i | input | RATIO_W | Second prescaler exponent |
| delay_i | input | DELAY_W | Post-edge delay in slow ticks |
| timeout_i | input | TMO_W | Edge wait limit in slow ticks, 0 = no limit |
| release_o | output | 1 | One-cycle release toward the transmit engine |
| timeout_o | output | 1 | One-cycle pulse when a release came from the wait limit |

## Verification
The bench sweeps the arrival of a TE edge across the cycles around the wait limit. A design that let the timeout win the tie, or that counted one slow tick too many or too few, would release a cycle off or flag a timeout that should not exist. It runs the same total slow-tick period through different splits between the two prescaler stages. A design that added the exponents wrongly, or restarted only one stage on the edge, would stretch or shrink the delay. It also drives a TE level that is already high at start, edges of the wrong polarity, and repeated start requests while busy. A design that latched a stale edge or restarted on a second start would release early.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DELAY = 2'd2
    } te_state_e;

    localparam logic [1:0] MODE_RISE = 2'd1;
    localparam logic [1:0] MODE_FALL = 2'd2;
endpackage

// File: rtl/te_edge_detect.sv
module te_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } edge_regs_t;

    edge_regs_t r_d, r_q;

    always_comb begin
        r_d.meta = pin_i;
        r_d.sync = r_q.meta;
        r_d.prev = r_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rise_o = r_q.sync & ~r_q.prev;
    assign fall_o = ~r_q.sync & r_q.prev;
endmodule

// File: rtl/te_tick_gen.sv
module te_tick_gen #(
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic [RATIO_W-1:0] ratio0_i,
    input  logic [RATIO_W-1:0] ratio1_i,
    output logic               tick_o
);
    localparam int CNT_W = (1 << RATIO_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] stage0;
        logic [CNT_W-1:0] stage1;
    } tick_regs_t;

    tick_regs_t r_d, r_q;
    logic [CNT_W-1:0] limit0, limit1;
    logic tick0;

    always_comb begin
        limit0 = ~({CNT_W{1'b1}} << ratio0_i);
        limit1 = ~({CNT_W{1'b1}} << ratio1_i);
        tick0  = (r_q.stage0 == limit0);
        tick_o = tick0 && (r_q.stage1 == limit1);
        r_d    = r_q;
        if (clear_i) begin
            r_d = '0;
        end else begin
            r_d.stage0 = tick0 ? '0 : r_q.stage0 + 1'b1;
            if (tick0) r_d.stage1 = tick_o ? '0 : r_q.stage1 + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/te_start_sync.sv
module te_start_sync #(
    parameter int RATIO_W = 4,
    parameter int DELAY_W = 8,
    parameter int TMO_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               te_i,
    input  logic               start_i,
    input  logic [1:0]         mode_i,
    input  logic [RATIO_W-1:0] ratio0_i,
    input  logic [RATIO_W-1:0] ratio1_i,
    input  logic [DELAY_W-1:0] delay_i,
    input  logic [TMO_W-1:0]   timeout_i,
    output logic               release_o,
    output logic               timeout_o
);
    import te_sync_pkg::*;

    localparam int CW = (DELAY_W > TMO_W) ? DELAY_W : TMO_W;

    typedef struct packed {
        te_state_e   state;
        logic [1:0]  mode;
        logic [CW-1:0] cnt;
        logic        rel;
        logic        tmo;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;
    logic rise, fall, tick, clear, hit, busy;
    logic [CW:0] cnt_next;

    te_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (te_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    te_tick_gen #(.RATIO_W(RATIO_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .ratio0_i (ratio0_i),
        .ratio1_i (ratio1_i),
        .tick_o   (tick)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rel  = 1'b0;
        r_d.tmo  = 1'b0;
        clear    = 1'b0;
        cnt_next = {1'b0, r_q.cnt} + 1'b1;
        hit      = (r_q.mode == MODE_RISE) ? rise : fall;
        unique case (r_q.state)
            ST_IDLE: begin
                clear = 1'b1;
                if (start_i) begin
                    if (mode_i == MODE_RISE || mode_i == MODE_FALL) begin
                        r_d.state = ST_WAIT;
                        r_d.mode  = mode_i;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.rel = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (hit) begin
                    clear   = 1'b1;
                    r_d.cnt = '0;
                    if (delay_i == '0) begin
                        r_d.rel   = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_DELAY;
                    end
                end else if (tick) begin
                    r_d.cnt = cnt_next[CW-1:0];
                    if (timeout_i != '0 && cnt_next == (CW+1)'(timeout_i)) begin
                        r_d.rel   = 1'b1;
                        r_d.tmo   = 1'b1;
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_DELAY: begin
                if (tick) begin
                    r_d.cnt = cnt_next[CW-1:0];
                    if (cnt_next == (CW+1)'(delay_i)) begin
                        r_d.rel   = 1'b1;
                        r_d.state = ST_IDLE;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, mode: '0, cnt: '0, rel: 1'b0, tmo: 1'b0};
        else        r_q <= r_d;
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign release_o = r_q.rel;
    assign timeout_o = r_q.tmo;
endmodule

// File: rtl/te_start_sync_chk.sv
module te_start_sync_chk #(
    parameter int TMO_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [1:0]       mode_i,
    input logic [TMO_W-1:0] timeout_i,
    input logic             busy_i,
    input logic             release_o,
    input logic             timeout_o
);
    p_nosync_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_i && (mode_i[1] == mode_i[0])) |=> release_o);

    p_timeout_with_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> release_o);

    p_no_limit_no_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i == '0 && $stable(timeout_i)) |-> !timeout_o);

    p_release_returns_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> !busy_i);

    p_timeout_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);
endmodule

bind te_start_sync te_start_sync_chk #(.TMO_W(TMO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .timeout_i (timeout_i),
    .busy_i    (busy),
    .release_o (release_o),
    .timeout_o (timeout_o)
);

// File: tb/sim_te_start_sync.sv
`timescale 1ns/1ps
module sim_te_start_sync;
    localparam int RW = 4;
    localparam int DW = 8;
    localparam int TW = 8;

    logic clk = 1'b0, rst_n = 1'b0, te = 1'b0, start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [RW-1:0] r0 = '0, r1 = '0;
    logic [DW-1:0] dly = '0;
    logic [TW-1:0] tmo = '0;
    logic rel, tout;

    int n_cmp = 0, n_bad = 0;
    string req = "R9";
    bit done = 1'b0;

    int m_st = 0, m_mode = 0, m_el = 0;
    bit s1, s2, s3, e_rel, e_to;

    always #2.5 clk = ~clk;

    te_start_sync #(.RATIO_W(RW), .DELAY_W(DW), .TMO_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .te_i(te), .start_i(start), .mode_i(mode),
        .ratio0_i(r0), .ratio1_i(r1), .delay_i(dly), .timeout_i(tmo),
        .release_o(rel), .timeout_o(tout)
    );

    task automatic model_step();
        bit rise, fall, hit;
        int per;
        if (!rst_n) begin
            m_st = 0; s1 = 0; s2 = 0; s3 = 0; e_rel = 0; e_to = 0;
            return;
        end
        rise = s2 && !s3;
        fall = !s2 && s3;
        s3 = s2; s2 = s1; s1 = te;
        per = 1 << (int'(r0) + int'(r1));
        e_rel = 0; e_to = 0;
        case (m_st)
            0: if (start) begin
                if (mode == 2'd1 || mode == 2'd2) begin
                    m_st = 1; m_mode = int'(mode); m_el = 0;
                end else e_rel = 1;
            end
            1: begin
                m_el++;
                hit = (m_mode == 1) ? rise : fall;
                if (hit) begin
                    if (dly == 0) begin e_rel = 1; m_st = 0; end
                    else begin m_st = 2; m_el = 0; end
                end else if (tmo != 0 && m_el == int'(tmo) * per) begin
                    e_rel = 1; e_to = 1; m_st = 0;
                end
            end
            default: begin
                m_el++;
                if (m_el == int'(dly) * per) begin e_rel = 1; m_st = 0; end
            end
        endcase
    endtask

    task automatic compare();
        n_cmp++;
        if (rel !== e_rel || tout !== e_to) begin
            n_bad++;
            $display("FAIL %s: release=%b timeout=%b expected release=%b timeout=%b at %0t",
                     req, rel, tout, e_rel, e_to, $time);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic kick(int md);
        mode = 2'(md); start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    initial begin
        req = "R9"; step(3);
        rst_n = 1'b1; step(2);

        req = "R1"; kick(0); step(2); kick(3); kick(0); step(2);

        req = "R2"; dly = 0; kick(1); step(5); te = 1; step(6);
        req = "R3"; kick(2); step(3); te = 0; step(6);

        req = "R4"; r0 = 1; r1 = 1; dly = 3; kick(2); step(2);
        te = 1; step(3); te = 0; step(20);

        req = "R5"; dly = 2;
        for (int k = 0; k < 3; k++) begin
            r0 = RW'(k); r1 = RW'(2 - k); te = 0; step(4);
            kick(1); step(3); te = 1; step(14);
        end
        r0 = 1; r1 = 2; te = 0; step(4); kick(1); step(2); te = 1; step(24);

        req = "R6"; r0 = 1; r1 = 0; tmo = 3; dly = 1; te = 0; step(4);
        kick(1); step(10);
        for (int j = 1; j <= 8; j++) begin
            te = 0; step(6);
            kick(1); step(j - 1); te = 1; step(12);
        end

        req = "R7"; tmo = 0; r0 = 0; r1 = 0; dly = 0; te = 0; step(4);
        kick(1); step(60); te = 1; step(5);

        req = "R8"; te = 1; step(3); kick(2); step(2); kick(1); kick(0);
        te = 0; te = 1; step(3); te = 0; step(5); tmo = 4; step(2);
        kick(1); step(1); te = 0; step(20);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule